// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-word SPI master that software drives through a small 32-bit register bus (address, write strobe, write data, combinational read data). Software picks a chip-select number and an assert bit, a clock mode and a frame width, then writes a word to the transmit register. That write starts one frame of 8 or 16 bits, sent MSB first on MOSI, while MISO is shifted into the receive register.

The serial clock has no divider of its own. An enable pulse from an external divider (`sck_en_i`) sets the rate, and each pulse produces one SCK edge. A completion flag in the cause register reads zero while a frame is in flight and one after it ends, so software can poll it. The MISO capture point can be moved one system clock later, which gives the fastest mode-3 reads more timing margin.

Top module: `spi_reg_master`

## Requirements
- R1: After reset, every `cs_no_o` bit is high, `sck_o` is 0, and the registers read as follows: cause 0, receive 0, configuration 0, control 0, and timing 0x40 (sample field = 1).
- R2: Register offsets: 0x00 control (bit 0 assert, bits 4:2 chip-select number), 0x04 configuration (bit 5 16-bit frame, bit 11 CPOL, bit 12 CPHA), 0x08 transmit, 0x0C receive, 0x10 cause, 0x18 timing (bits 7:6 sample field). Undefined bits and undefined offsets read 0.
- R3: While control bit 0 is 1, only `cs_no_o[n]` is low, where n is control bits 4:2. While it is 0, all chip selects are high. A chip select stays asserted across back-to-back frames.
- R4: A transmit write while idle starts a frame. With configuration bit 5 clear, the frame is 8 bits long, sent MSB first from write bits 7:0, and the higher write bits are ignored.
- R5: With configuration bit 5 set, the frame is 16 bits long and is sent MSB first from write bits 15:0.
- R6: While idle, SCK rests at CPOL. With CPHA=0, MOSI is valid before the first edge, MISO is sampled on odd edges and MOSI changes on even edges. With CPHA=1, MOSI changes on odd edges from the third onward and MISO is sampled on even edges.
- R7: The receive register returns the bits captured during the last frame, MSB first: 8 bits zero-extended, or 16 bits.
- R8: A started frame clears the cause register, which stays 0 until the frame ends and then reads 1. Writing 0 to the cause register clears it. A nonzero write leaves it unchanged.
- R9: A transmit write while a frame is in flight is ignored. The frame in progress, its MOSI bits and its received data are unchanged.
- R10: With sample field 1, MISO is captured in the clock of the sampling SCK edge. With field 2, it is captured one system clock later, and the cause register rises one clock after the last edge.
- R11: SCK changes only in clocks where `sck_en_i` is high. A frame has exactly twice as many SCK edges as it has bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| sck_en_i | input | 1 | Edge enable from the external clock divider |
| miso_i | input | 1 | Serial data from the selected slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_no_o | output | 8 | Active-low chip selects |

## Verification
On every cycle, the assertions check the following: at most one chip select is low; SCK rests at CPOL while the engine is idle and moves only on divider pulses; the edge count never exceeds twice the frame length; and the completion flag is cleared by a start and rises only at a frame end. The bench scenarios cover the rest. Only they can show the MSB-first bit order in each of the four clock modes, the value the receive register returns under both sample delays, that an overlapping transmit write is ignored, and that the cause register clears only on a zero write. To do this, the bench compares SCK, MOSI and the chip selects against a behavioural model on every clock.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_CFG   = 'h04;
  localparam int unsigned OFF_TX    = 'h08;
  localparam int unsigned OFF_RX    = 'h0C;
  localparam int unsigned OFF_CAUSE = 'h10;
  localparam int unsigned OFF_TIM   = 'h18;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_CS_LSB  = 2;
  localparam int unsigned CFG_WIDE_BIT = 5;
  localparam int unsigned CFG_CPOL_BIT = 11;
  localparam int unsigned CFG_CPHA_BIT = 12;
  localparam int unsigned TIM_DLY_LSB  = 6;

  localparam logic [1:0] DLY_RESET = 2'd1;
  localparam logic [1:0] DLY_LATE  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} shift_state_e;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CS_W     = 3,
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               busy_i,
  input  logic               frame_end_i,
  input  logic [FRAME_W-1:0] rx_i,
  output logic               cs_en_o,
  output logic [CS_W-1:0]    cs_sel_o,
  output logic               cpol_o,
  output logic               cpha_o,
  output logic               wide_o,
  output logic               dly_late_o,
  output logic               start_o,
  output logic [FRAME_W-1:0] tx_o
);
  logic            cs_en_q, cpol_q, cpha_q, wide_q, done_q;
  logic [CS_W-1:0] cs_sel_q;
  logic [1:0]      dly_q;

  logic hit_ctrl, hit_cfg, hit_tx, hit_rx, hit_cause, hit_tim;
  assign hit_ctrl  = addr_i == ADDR_W'(OFF_CTRL);
  assign hit_cfg   = addr_i == ADDR_W'(OFF_CFG);
  assign hit_tx    = addr_i == ADDR_W'(OFF_TX);
  assign hit_rx    = addr_i == ADDR_W'(OFF_RX);
  assign hit_cause = addr_i == ADDR_W'(OFF_CAUSE);
  assign hit_tim   = addr_i == ADDR_W'(OFF_TIM);

  assign start_o = we_i && hit_tx && !busy_i;
  assign tx_o    = wdata_i[FRAME_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_en_q  <= 1'b0;
      cs_sel_q <= '0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      wide_q   <= 1'b0;
      dly_q    <= DLY_RESET;
      done_q   <= 1'b0;
    end else begin
      if (we_i && hit_ctrl) begin
        cs_en_q  <= wdata_i[CTRL_EN_BIT];
        cs_sel_q <= wdata_i[CTRL_CS_LSB +: CS_W];
      end
      if (we_i && hit_cfg) begin
        wide_q <= wdata_i[CFG_WIDE_BIT];
        cpol_q <= wdata_i[CFG_CPOL_BIT];
        cpha_q <= wdata_i[CFG_CPHA_BIT];
      end
      if (we_i && hit_tim) dly_q <= wdata_i[TIM_DLY_LSB +: 2];
      if (start_o)                                  done_q <= 1'b0;
      else if (frame_end_i)                         done_q <= 1'b1;
      else if (we_i && hit_cause && wdata_i == '0)  done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[CTRL_EN_BIT]           = cs_en_q;
      rdata_o[CTRL_CS_LSB +: CS_W]   = cs_sel_q;
    end
    if (hit_cfg) begin
      rdata_o[CFG_WIDE_BIT] = wide_q;
      rdata_o[CFG_CPOL_BIT] = cpol_q;
      rdata_o[CFG_CPHA_BIT] = cpha_q;
    end
    if (hit_rx)    rdata_o[FRAME_W-1:0] = wide_q ? rx_i : FRAME_W'(rx_i[NARROW_W-1:0]);
    if (hit_cause) rdata_o[0] = done_q;
    if (hit_tim)   rdata_o[TIM_DLY_LSB +: 2] = dly_q;
  end

  assign cs_en_o    = cs_en_q;
  assign cs_sel_o   = cs_sel_q;
  assign cpol_o     = cpol_q;
  assign cpha_o     = cpha_q;
  assign wide_o     = wide_q;
  assign dly_late_o = dly_q == DLY_LATE;

  // R8
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(frame_end_i));
  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !done_q);
endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift
  import spi_rm_pkg::*;
#(
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_i,
  input  logic               wide_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               dly_late_i,
  input  logic               tick_i,
  input  logic               miso_i,
  output logic               busy_o,
  output logic               frame_end_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               sck_o,
  output logic               mosi_o
);
  localparam int unsigned CNT_W = $clog2(2 * FRAME_W + 1);
  localparam logic [CNT_W-1:0] EDGES_WIDE   = CNT_W'(2 * FRAME_W);
  localparam logic [CNT_W-1:0] EDGES_NARROW = CNT_W'(2 * NARROW_W);

  shift_state_e       state_q;
  logic [CNT_W-1:0]   ecnt_q, edge_k, edges_tot;
  logic [FRAME_W-1:0] sh_q, rx_q;
  logic               sck_q, pend_q, wide_q;
  logic               edge_go, lead, samp_edge, shift_edge, last_edge, cap_now;

  assign edges_tot  = wide_q ? EDGES_WIDE : EDGES_NARROW;
  assign edge_go    = (state_q == ST_SHIFT) && tick_i;
  assign edge_k     = ecnt_q + 1'b1;
  assign lead       = edge_k[0];
  assign samp_edge  = cpha_i ? !lead : lead;
  assign shift_edge = cpha_i ? (lead && ecnt_q >= CNT_W'(2)) : !lead;
  assign last_edge  = edge_k == edges_tot;
  assign cap_now    = dly_late_i ? pend_q : (edge_go && samp_edge);
  assign frame_end_o = (edge_go && last_edge && !dly_late_i) || (state_q == ST_TAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      pend_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      pend_q <= edge_go && samp_edge;
      if (cap_now) rx_q <= {rx_q[FRAME_W-2:0], miso_i};
      unique case (state_q)
        ST_IDLE: begin
          sck_q <= cpol_i;
          if (start_i) begin
            state_q <= ST_SHIFT;
            ecnt_q  <= '0;
            wide_q  <= wide_i;
            rx_q    <= '0;
            sh_q    <= wide_i ? tx_i : {tx_i[NARROW_W-1:0], (FRAME_W - NARROW_W)'(0)};
          end
        end
        ST_SHIFT: if (tick_i) begin
          sck_q  <= !sck_q;
          ecnt_q <= edge_k;
          if (shift_edge) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
          if (last_edge) state_q <= dly_late_i ? ST_TAIL : ST_IDLE;
        end
        ST_TAIL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[FRAME_W-1];

  // R11
  sck_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !tick_i) |=> $stable(sck_q));
  // R11
  edge_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecnt_q <= edges_tot);
  // R6
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q == ST_IDLE) && $stable(cpol_i)) |-> sck_q == cpol_i);
endmodule

// File: rtl/spi_rm_cs_dec.sv
module spi_rm_cs_dec #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned CS_W   = 3
) (
  input  logic              en_i,
  input  logic [CS_W-1:0]   sel_i,
  output logic [NUM_CS-1:0] cs_no
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(en_i && sel_i == CS_W'(g));
  end
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_rm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_CS   = 8,
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sck_en_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_no_o
);
  localparam int unsigned CS_W = $clog2(NUM_CS);

  logic               cs_en, cpol, cpha, wide, dly_late, start, busy, frame_end;
  logic [CS_W-1:0]    cs_sel;
  logic [FRAME_W-1:0] tx, rx;

  spi_rm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_W(CS_W),
    .FRAME_W(FRAME_W), .NARROW_W(NARROW_W)
  ) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .frame_end_i(frame_end), .rx_i(rx),
    .cs_en_o(cs_en), .cs_sel_o(cs_sel), .cpol_o(cpol), .cpha_o(cpha),
    .wide_o(wide), .dly_late_o(dly_late), .start_o(start), .tx_o(tx)
  );

  spi_rm_shift #(.FRAME_W(FRAME_W), .NARROW_W(NARROW_W)) i_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_i(tx), .wide_i(wide),
    .cpol_i(cpol), .cpha_i(cpha), .dly_late_i(dly_late), .tick_i(sck_en_i),
    .miso_i, .busy_o(busy), .frame_end_o(frame_end), .rx_o(rx),
    .sck_o, .mosi_o
  );

  spi_rm_cs_dec #(.NUM_CS(NUM_CS), .CS_W(CS_W)) i_cs (
    .en_i(cs_en), .sel_i(cs_sel), .cs_no(cs_no_o)
  );

  // R3
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no_o));
endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, sck_en = 1'b0, miso = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi;
  logic [7:0]  cs_n;

  int total = 0, bad = 0, cycles = 0;
  int tick_per = 2, tick_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state
  logic [31:0] m_ctrl, m_cfg, m_tx;
  logic [1:0]  m_tim;
  logic [15:0] m_rx;
  bit          m_cause, m_busy, m_tail, m_pend, m_sck, m_fw;
  int          m_edges;

  spi_reg_master i_spi_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sck_en_i(sck_en), .miso_i(miso), .sck_o(sck),
    .mosi_o(mosi), .cs_no_o(cs_n)
  );

  always #4 clk = !clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (tick_cnt + 1 >= tick_per) begin tick_cnt = 0; sck_en = 1'b1; end
    else begin tick_cnt++; sck_en = 1'b0; end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cfg = 0; m_tx = 0; m_tim = 2'd1; m_rx = 0;
      m_cause = 0; m_busy = 0; m_tail = 0; m_pend = 0; m_sck = 0; m_fw = 0; m_edges = 0;
    end else begin
      automatic bit late = (m_tim == 2'd2);
      automatic bit was_busy = m_busy;
      automatic bit nxt_pend = 0;
      automatic int n = m_fw ? 16 : 8;
      if (late && m_pend) m_rx = {m_rx[14:0], miso};
      if (m_tail) begin
        m_tail = 0; m_busy = 0; m_cause = 1;
      end else if (m_busy && sck_en) begin
        automatic int k = m_edges + 1;
        automatic bit lead = (k % 2) == 1;
        automatic bit samp = m_cfg[12] ? !lead : lead;
        if (samp) begin
          if (!late) m_rx = {m_rx[14:0], miso};
          nxt_pend = 1;
        end
        m_sck = !m_sck;
        m_edges = k;
        if (k == 2 * n) begin
          if (late) m_tail = 1;
          else begin m_busy = 0; m_cause = 1; end
        end
      end else if (!m_busy) m_sck = m_cfg[11];
      m_pend = nxt_pend;
      if (we) begin
        case (addr)
          8'h00: m_ctrl = wdata & 32'h1D;
          8'h04: m_cfg  = wdata & 32'h1820;
          8'h10: if (wdata == 0) m_cause = 0;
          8'h18: m_tim  = wdata[7:6];
          8'h08: if (!was_busy) begin
            m_busy = 1; m_edges = 0; m_fw = m_cfg[5]; m_tx = wdata; m_rx = 0; m_cause = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [7:0] exp_cs = m_ctrl[0] ? ~(8'b1 << m_ctrl[4:2]) : 8'hFF;
      chk(sck == m_sck, "R6/R11 sck", {31'b0, sck}, {31'b0, m_sck});
      chk(cs_n == exp_cs, "R3 cs", {24'b0, cs_n}, {24'b0, exp_cs});
      if (m_busy && !m_tail) begin
        automatic int n = m_fw ? 16 : 8;
        automatic int sh = m_cfg[12] ? ((m_edges >= 1) ? (m_edges - 1) / 2 : 0) : m_edges / 2;
        if (sh < n)
          chk(mosi == m_tx[n-1-sh], "R4/R5/R9 mosi", {31'b0, mosi}, {31'b0, m_tx[n-1-sh]});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic run_frame(input logic [31:0] cfg, input logic [31:0] data, input int per,
                           input bit overlap, input string tag);
    logic [31:0] v, exp;
    tick_per = per;
    wr(8'h04, cfg);
    wr(8'h10, 0);
    wr(8'h08, data);
    rd(8'h10, v);
    chk(v == 0, "R8 busy cause", v, 0);
    if (overlap) wr(8'h08, ~data);
    for (int i = 0; i < 3000; i++) begin
      rd(8'h10, v);
      if (v != 0) break;
    end
    chk(v == 1, "R8 done cause", v, 1);
    exp = m_fw ? {16'b0, m_rx} : {24'b0, m_rx[7:0]};
    rd(8'h0C, v);
    chk(v == exp, tag, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h10, v); chk(v == 0, "R1 cause", v, 0);
    rd(8'h0C, v); chk(v == 0, "R1 rx", v, 0);
    rd(8'h18, v); chk(v == 32'h40, "R1 timing", v, 32'h40);
    rd(8'h04, v); chk(v == 0, "R1 cfg", v, 0);
    rd(8'h00, v); chk(v == 0, "R1 ctrl", v, 0);
    chk(cs_n == 8'hFF, "R1 cs", {24'b0, cs_n}, 32'hFF);
    // R2 register map readback with masking
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == 32'h1D, "R2 ctrl", v, 32'h1D);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk(v == 32'h1820, "R2 cfg", v, 32'h1820);
    rd(8'h20, v); chk(v == 0, "R2 unmapped", v, 0);
    // R3 select line 5
    wr(8'h00, 32'h15);
    rd(8'h00, v); chk(v == 32'h15, "R3 ctrl", v, 32'h15);
    // R4 8-bit mode 0, upper bits ignored
    run_frame(32'h0, 32'h1234_56A5, 2, 0, "R4 R7 rx mode0 8b");
    run_frame(32'h0, 32'h0000_003C, 1, 0, "R4 R7 rx mode0 fast");
    // R5 16-bit, modes 1..3
    run_frame(32'h1020, 32'hFFFF_B37D, 3, 0, "R5 R6 rx mode1 16b");
    run_frame(32'h0820, 32'h0000_8001, 2, 0, "R5 R6 rx mode2 16b");
    run_frame(32'h1800, 32'h0000_00C3, 1, 0, "R6 R7 rx mode3 8b");
    // R9 overlapping write ignored
    run_frame(32'h0020, 32'h0000_5AF0, 4, 1, "R9 rx overlap");
    // R10 late sampling
    wr(8'h18, 32'h80);
    rd(8'h18, v); chk(v == 32'h80, "R10 timing", v, 32'h80);
    run_frame(32'h1820, 32'h0000_E61B, 1, 0, "R10 rx late mode3 every clk");
    run_frame(32'h1800, 32'h0000_0096, 2, 0, "R10 rx late mode3");
    run_frame(32'h0000, 32'h0000_0071, 3, 0, "R10 rx late mode0");
    wr(8'h18, 32'h40);
    // R8 cause clear semantics
    wr(8'h10, 32'h1);
    rd(8'h10, v); chk(v == 1, "R8 nonzero write keeps", v, 1);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk(v == 0, "R8 zero write clears", v, 0);
    // R3 other lines and deassert
    wr(8'h00, 32'h1D);
    run_frame(32'h0, 32'h0000_00FF, 2, 0, "R3 rx cs7");
    wr(8'h00, 32'h01);
    run_frame(32'h0, 32'h0000_0000, 2, 0, "R3 rx cs0");
    wr(8'h00, 32'h00);
    @(negedge clk);
    chk(cs_n == 8'hFF, "R3 deassert", {24'b0, cs_n}, 32'hFF);
    // R11 no edges without enable
    tick_per = 1000;
    wr(8'h08, 32'h55);
    repeat (20) @(negedge clk);
    chk(sck == 1'b0, "R11 no enable no edge", {31'b0, sck}, 0);
    tick_per = 1;
    repeat (60) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule